// File: doc/BRIEF.md
# Tester-to-Scan Rate Adapter

The adapter sits between a few tester pins and a wider, slower test access bus inside a chip. Some of the tester pins, the fast pins, carry data at `RATE` times the scan rate. Each fast pin is gathered by a shift register into a group of `RATE` slow lines. The other tester pins, the slow pins, each feed one slow line. Together these lines form a virtual bus of `FAST_PINS*RATE + (PINS-FAST_PINS)` lines, which is ten lines with the default parameters. In the other direction, each group of `RATE` slow response lines is loaded into a shift register and sent back, one bit per fast cycle, on its fast pin. Each slow response line returns on its own slow pin.

Everything runs on a single fast clock. A phase counter divides the fast clock by `RATE` into slots and produces a one-cycle scan enable. At each slot boundary the adapter does two things at the same edge: it presents the gathered stimulus word to the bus, and it captures the core responses. Each direction therefore has a latency of exactly one slot. The elaborator rejects a configuration whose virtual bus is wider than the bound `WIDTH_MAX`.

Top module: `bwm_adapter`

## Requirements
- R1: The virtual bus width is `FAST_PINS*RATE + (PINS-FAST_PINS)`. Elaboration fails if this width exceeds `WIDTH_MAX`, if `RATE < 2`, or if `FAST_PINS > PINS`.
- R2: `scan_en` is high for exactly one fast cycle in every `RATE` fast cycles. After reset is released, it first rises in fast cycle number `RATE`, counting the first cycle out of reset as cycle 0.
- R3: A fast stimulus pin j is sampled once per fast cycle. The bit sampled in phase p of a slot (p = 0 first) drives bus line `j*RATE+p`. Fast pins occupy pin indices 0 to FAST_PINS-1.
- R4: A slow stimulus pin `FAST_PINS+k` is sampled in the last phase of a slot and drives bus line `FAST_PINS*RATE+k`.
- R5: `tam_si` changes only at the edge that ends a slot, which is the same edge at which `scan_en` rises. All lines change together, and the word stays on the bus for the whole next slot.
- R6: At the edge that ends a slot, `tam_so` is captured. During phase p of the next slot, fast response pin j shows captured line `j*RATE+p`, so bit 0 goes out first.
- R7: Slow response pin `FAST_PINS+k` shows captured line `FAST_PINS*RATE+k` for the whole slot that follows the capture.
- R8: A synchronous reset returns the phase to 0 and clears every shift and holding register. This holds even in the middle of a slot. `tam_si`, `ate_so` and `scan_en` stay at zero until the first full slot after reset has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (tester-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| ate_si | input | PINS | Stimulus tester pins, fast pins at the low indices |
| ate_so | output | PINS | Response tester pins, same index layout |
| scan_en | output | 1 | One-cycle slow scan enable; marks a fresh bus word |
| tam_si | output | VW | Virtual bus stimulus lines |
| tam_so | input | VW | Virtual bus response lines from the cores |

## Verification
Presenting stimulus and capturing responses both happen on the slot-boundary edge. In the same cycle, each response shift register loads instead of shifting. The bench sweeps all 1024 ten-bit stimulus words. It pairs each word with a response taken from an odd-multiplier permutation, so that both the stimulus and the response change at every boundary. In the cycle where `scan_en` is high, it checks the new bus word together with bit 0 of the freshly captured response. A stale load, or a shift applied at the boundary, shows up as a mismatch there. A reset in the middle of a slot is used to check that the phase restarts.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

   // Number of slow lines formed from the tester pins
   function automatic int vtam_width(input int rate, input int pins, input int fast);
      return fast * rate + (pins - fast);
   endfunction

   function automatic int phase_bits(input int rate);
      return (rate > 2) ? $clog2(rate) : 1;
   endfunction

endpackage

// File: rtl/bwm_phase.sv
module bwm_phase #(
   parameter int RATE = 4
) (
   input  logic clk,
   input  logic rst,
   output logic wrap,
   output logic scan_en
);
   localparam int PHW = bwm_pkg::phase_bits(RATE);
   localparam logic [PHW-1:0] LAST = PHW'(RATE - 1);

   logic [PHW-1:0] phase;

   assign wrap = (phase == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= '0;
         scan_en <= 1'b0;
      end else begin
         phase   <= wrap ? '0 : phase + 1'b1;
         scan_en <= wrap;
      end
   end
endmodule

// File: rtl/bwm_sipo.sv
module bwm_sipo #(
   parameter int RATE = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wrap,
   input  logic            din,
   output logic [RATE-1:0] word
);
   logic [RATE-1:0] shreg;
   logic [RATE-1:0] next_shreg;

   // newest bit enters at the top; the first bit of a slot lands in bit 0
   assign next_shreg = {din, shreg[RATE-1:1]};

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg <= '0;
         word  <= '0;
      end else begin
         shreg <= next_shreg;
         if (wrap) word <= next_shreg;
      end
   end
endmodule

// File: rtl/bwm_piso.sv
module bwm_piso #(
   parameter int RATE = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wrap,
   input  logic [RATE-1:0] par,
   output logic            dout
);
   logic [RATE-1:0] shreg;

   assign dout = shreg[0];

   always_ff @(posedge clk) begin
      if (rst)       shreg <= '0;
      else if (wrap) shreg <= par;
      else           shreg <= {1'b0, shreg[RATE-1:1]};
   end
endmodule

// File: rtl/bwm_adapter.sv
module bwm_adapter
   import bwm_pkg::*;
#(
   parameter int RATE      = 4,
   parameter int PINS      = 4,
   parameter int FAST_PINS = 2,
   parameter int WIDTH_MAX = 10,
   localparam int VW       = vtam_width(RATE, PINS, FAST_PINS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PINS-1:0] ate_si,
   output logic [PINS-1:0] ate_so,
   output logic          scan_en,
   output logic [VW-1:0] tam_si,
   input  logic [VW-1:0] tam_so
);
   localparam int SLOW_PINS = PINS - FAST_PINS;
   localparam int SLOW_BASE = FAST_PINS * RATE;

   // R1: configuration checks at elaboration
   if (RATE < 2) begin : g_bad_rate
      $error("bwm_adapter: RATE must be at least 2");
   end
   if (FAST_PINS > PINS || FAST_PINS < 0) begin : g_bad_fast
      $error("bwm_adapter: FAST_PINS out of range");
   end
   if (VW > WIDTH_MAX) begin : g_bad_width
      $error("bwm_adapter: virtual bus width exceeds WIDTH_MAX");
   end

   logic wrap;

   bwm_phase #(.RATE(RATE)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .wrap    (wrap),
      .scan_en (scan_en)
   );

   for (genvar j = 0; j < FAST_PINS; j++) begin : g_fast
      bwm_sipo #(.RATE(RATE)) u_sipo (
         .clk  (clk),
         .rst  (rst),
         .wrap (wrap),
         .din  (ate_si[j]),
         .word (tam_si[j*RATE +: RATE])
      );
      bwm_piso #(.RATE(RATE)) u_piso (
         .clk  (clk),
         .rst  (rst),
         .wrap (wrap),
         .par  (tam_so[j*RATE +: RATE]),
         .dout (ate_so[j])
      );
   end

   for (genvar k = 0; k < SLOW_PINS; k++) begin : g_slow
      always_ff @(posedge clk) begin
         if (rst) begin
            tam_si[SLOW_BASE+k]  <= 1'b0;
            ate_so[FAST_PINS+k]  <= 1'b0;
         end else if (wrap) begin
            tam_si[SLOW_BASE+k]  <= ate_si[FAST_PINS+k];
            ate_so[FAST_PINS+k]  <= tam_so[SLOW_BASE+k];
         end
      end
   end
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
   parameter int RATE      = 4,
   parameter int PINS      = 4,
   parameter int FAST_PINS = 2,
   parameter int VW        = 10
) (
   input logic            clk,
   input logic            rst,
   input logic            scan_en,
   input logic [VW-1:0]   tam_si,
   input logic [VW-1:0]   tam_so,
   input logic [PINS-1:0] ate_so
);
   localparam int CW = $clog2(RATE + 1) + 1;
   logic [CW-1:0] gap;

   always_ff @(posedge clk) begin
      if (rst)          gap <= '0;
      else if (scan_en) gap <= CW'(1);
      else              gap <= gap + 1'b1;
   end

   a_r2_enable_period: assert property (@(posedge clk) disable iff (rst)
      scan_en |-> gap == CW'(RATE));

   a_r2_enable_single: assert property (@(posedge clk) disable iff (rst)
      scan_en |=> !scan_en);

   a_r5_bus_moves_with_enable: assert property (@(posedge clk) disable iff (rst)
      !$stable(tam_si) |-> scan_en);

   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (rst || (tam_si == '0 && ate_so == '0 && !scan_en)));

   for (genvar j = 0; j < FAST_PINS; j++) begin : g_fast_chk
      a_r6_fast_first_bit: assert property (@(posedge clk) disable iff (rst)
         scan_en |-> ate_so[j] == $past(tam_so[j*RATE]));
   end

   for (genvar k = 0; k < PINS - FAST_PINS; k++) begin : g_slow_chk
      a_r7_slow_resp: assert property (@(posedge clk) disable iff (rst)
         scan_en |-> ate_so[FAST_PINS+k] == $past(tam_so[FAST_PINS*RATE+k]));
   end
endmodule

bind bwm_adapter bwm_checker #(
   .RATE(RATE), .PINS(PINS), .FAST_PINS(FAST_PINS), .VW(VW)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .scan_en (scan_en),
   .tam_si  (tam_si),
   .tam_so  (tam_so),
   .ate_so  (ate_so)
);

// File: tb/tb_bwm_adapter.sv
`timescale 1ns/1ps
module tb_bwm_adapter;
   localparam int RATE = 4;
   localparam int PINS = 4;
   localparam int FASTP = 2;
   localparam int VW = FASTP * RATE + (PINS - FASTP);
   localparam int SB = FASTP * RATE;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [PINS-1:0] ate_si = '0;
   logic [PINS-1:0] ate_so;
   logic scan_en;
   logic [VW-1:0] tam_si;
   logic [VW-1:0] tam_so = '0;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bwm_adapter #(.RATE(RATE), .PINS(PINS), .FAST_PINS(FASTP), .WIDTH_MAX(10)) dut (
      .clk(clk), .rst(rst), .ate_si(ate_si), .ate_so(ate_so),
      .scan_en(scan_en), .tam_si(tam_si), .tam_so(tam_so)
   );

   function automatic logic [VW-1:0] stim(input int v);
      return VW'(v);
   endfunction

   function automatic logic [VW-1:0] resp(input int v);
      return VW'(v * 397 + 5);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; ate_si = '0; tam_so = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // entered at a negedge just after reset release; phase 0 is the next edge
   task automatic run(input int nslot, input int base);
      for (int cyc = 0; cyc < (nslot + 1) * RATE; cyc++) begin
         int slot;
         int ph;
         logic [VW-1:0] ws;
         logic [VW-1:0] wr;
         logic [PINS-1:0] eo;
         slot = cyc / RATE;
         ph = cyc % RATE;
         if (slot == 0) begin
            chk("R8 bus zero after reset", 32'(tam_si), 32'd0);
            chk("R8 pins zero after reset", 32'(ate_so), 32'd0);
            chk("R2 no enable before first slot", 32'(scan_en), 32'd0);
         end else begin
            ws = stim(base + slot - 1);
            wr = resp(base + slot - 1);
            for (int j = 0; j < FASTP; j++) eo[j] = wr[j*RATE + ph];
            for (int k = 0; k < PINS - FASTP; k++) eo[FASTP+k] = wr[SB+k];
            chk("R2 enable timing", 32'(scan_en), 32'(ph == 0));
            chk("R3 R4 R5 bus word", 32'(tam_si), 32'(ws));
            chk("R6 R7 response pins", 32'(ate_so), 32'(eo));
         end
         if (slot < nslot) begin
            ws = stim(base + slot);
            for (int j = 0; j < FASTP; j++) ate_si[j] = ws[j*RATE + ph];
            for (int k = 0; k < PINS - FASTP; k++) ate_si[FASTP+k] = ws[SB+k];
            tam_so = resp(base + slot);
         end else begin
            ate_si = '0;
            tam_so = '0;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      do_reset();
      run(1 << VW, 0);       // exhaustive over all stimulus words
      // R8: reset in the middle of a slot, then the phase must restart
      ate_si = '1; tam_so = '1;
      repeat (2) @(negedge clk);
      do_reset();
      run(8, 300);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule